// File: doc/BRIEF.md
# Interleaved Chip-Select Address Decoder

This block turns a memory-side address (already translated from the physical address space) into one of four DRAM chip selects. Each chip select owns a region at 16 MB granularity, given by a programmable lower bound and an exclusive upper bound. Both bounds are taken from the top sixteen address bits. A forty-bit interleave mask lets two or four regions that are programmed with the same bounds share one range. One or two address bits then pick which chip select serves each access.

Requests carry a valid flag, a read/write flag and the address. The decoder accepts one request in every cycle and never applies back-pressure, so the request side has no ready signal. Exactly one cycle later it presents a single-cycle response with the same valid. The response gives a one-hot chip-select vector or all zeros, a miss flag, and a bus-error flag. The bus-error flag is raised for a read that falls outside every region, unless the miss mode bit asks for such reads to come back as valid data. A write that misses is dropped and reports only the miss. A small register write port programs the bounds, the mask and the miss mode.

Top module: `csel_decoder`

## Requirements
- R1: A region's start register, taken as address bits [39:24] with bits [23:0] zero, is inclusive. An address whose top field equals start hits that region.
- R2: A region's end register, read the same way, is exclusive. An address whose top field equals end misses that region, and the address one byte below end hits it.
- R3: A region whose start and end are both zero never matches any address.
- R4: With a zero interleave mask, or any mask that is neither one set bit nor two adjacent set bits, the lowest-numbered matching region wins. rsp_cs is always one-hot or all zero.
- R5: With exactly one mask bit set, suppose the lowest matching region i and region i+1 both match. Then a zero in the masked address bit selects chip select i, and a one selects chip select i+1.
- R6: With two adjacent mask bits set and all four regions matching, the two masked address bits form the chip-select index. The lower mask bit is the index LSB, so values 0 to 3 select chip selects 0 to 3.
- R7: A request that matches no region gives rsp_cs = 0 and rsp_miss = 1. A write miss never raises rsp_berr.
- R8: A read miss raises rsp_berr when the miss mode bit is 0. When the mode bit is 1, the read miss is returned as valid data with rsp_berr = 0.
- R9: Every request accepted at a clock edge produces rsp_valid during the following cycle only, with no stall even for back-to-back requests. While rsp_valid is 0, rsp_cs, rsp_miss and rsp_berr are 0.
- R10: Register writes use cfg_addr as follows:
  - 0 to 3: start of chip select n, from cfg_wdata[15:0].
  - 4 to 7: end of chip select n-4, from cfg_wdata[15:0].
  - 8: the interleave mask, from cfg_wdata[39:0].
  - 9: the miss mode bit, from cfg_wdata[0].

  A write applies to requests from the next cycle on.
- R11: Reset clears all registers, so every region is unused and read misses report a bus error, and it clears all response outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 40 | Translated memory address |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register index (see R10) |
| cfg_wdata | input | 40 | Register write data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_cs | output | 4 | One-hot chip select, zero on a miss |
| rsp_miss | output | 1 | No region matched |
| rsp_berr | output | 1 | Read miss reported as bus error |

## Verification
On every cycle the assertions check the response framing:
- rsp_valid follows the previous cycle's req_valid.
- rsp_cs stays one-hot or zero.
- The miss flag agrees exactly with an empty chip-select vector.
- A bus error appears only for a read and only together with a miss.
- Outputs are quiet when no response is present.

Which chip select a given address selects can be shown only by the bench's scenarios. These cover the inclusive start and exclusive end, unused regions, lowest-index priority on overlap, and the two- and four-way interleave bit mapping. The scenarios also show that the miss mode bit switches read misses between bus error and valid data.

// File: rtl/csdec_pkg.sv
package csdec_pkg;
  localparam int NUM_CS = 4;
  localparam int IDX_W  = $clog2(NUM_CS);
  localparam int REG_W  = 4;

  // register index map
  localparam logic [REG_W-1:0] RIDX_START0 = 4'd0;
  localparam logic [REG_W-1:0] RIDX_END0   = 4'd4;
  localparam logic [REG_W-1:0] RIDX_MASK   = 4'd8;
  localparam logic [REG_W-1:0] RIDX_MODE   = 4'd9;

  typedef enum logic {
    MISS_BUSERR = 1'b0,
    MISS_VALID  = 1'b1
  } miss_mode_e;
endpackage

// File: rtl/csdec_regs.sv
module csdec_regs
  import csdec_pkg::*;
#(
  parameter int ADDR_W = 40,
  parameter int FW     = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         we,
  input  logic [REG_W-1:0]             waddr,
  input  logic [ADDR_W-1:0]            wdata,
  output logic [NUM_CS-1:0][FW-1:0]    lo_bound,
  output logic [NUM_CS-1:0][FW-1:0]    hi_bound,
  output logic [ADDR_W-1:0]            ilv_mask,
  output miss_mode_e                   miss_mode
);
  for (genvar g = 0; g < NUM_CS; g++) begin : g_bounds
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lo_bound[g] <= '0;
        hi_bound[g] <= '0;
      end else if (we) begin
        if (waddr == RIDX_START0 + REG_W'(g)) lo_bound[g] <= wdata[FW-1:0];
        if (waddr == RIDX_END0 + REG_W'(g))   hi_bound[g] <= wdata[FW-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ilv_mask  <= '0;
      miss_mode <= MISS_BUSERR;
    end else if (we) begin
      if (waddr == RIDX_MASK) ilv_mask <= wdata;
      if (waddr == RIDX_MODE) miss_mode <= miss_mode_e'(wdata[0]);
    end
  end
endmodule

// File: rtl/csdec_range_cmp.sv
module csdec_range_cmp
  import csdec_pkg::*;
#(
  parameter int FW = 16
) (
  input  logic [FW-1:0]              field,
  input  logic [NUM_CS-1:0][FW-1:0]  lo_bound,
  input  logic [NUM_CS-1:0][FW-1:0]  hi_bound,
  output logic [NUM_CS-1:0]          hit
);
  // inclusive lower, exclusive upper; start==end==0 can never hit
  for (genvar g = 0; g < NUM_CS; g++) begin : g_cmp
    assign hit[g] = (field >= lo_bound[g]) && (field < hi_bound[g]);
  end
endmodule

// File: rtl/csdec_select.sv
module csdec_select
  import csdec_pkg::*;
#(
  parameter int ADDR_W = 40
) (
  input  logic [NUM_CS-1:0]  hit,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [ADDR_W-1:0]  ilv_mask,
  output logic [NUM_CS-1:0]  cs_onehot
);
  localparam int LO_W = $clog2(ADDR_W);

  logic [LO_W-1:0]   lo;
  logic [ADDR_W-1:0] shifted;
  logic              one_bit, two_bit, b0, b1;
  logic [IDX_W-1:0]  first, pick;
  logic              nxt_hit;

  // position of the lowest set mask bit
  always_comb begin
    lo = '0;
    for (int k = ADDR_W - 1; k >= 0; k--) begin
      if (ilv_mask[k]) lo = LO_W'(k);
    end
  end

  assign one_bit = (ilv_mask != '0) && (ilv_mask == (ADDR_W'(1) << lo));
  assign two_bit = (lo != LO_W'(ADDR_W - 1)) && (ilv_mask == (ADDR_W'(3) << lo));
  assign shifted = addr >> lo;
  assign b0      = shifted[0];
  assign b1      = shifted[1];

  // lowest-numbered matching region
  always_comb begin
    first = '0;
    for (int k = NUM_CS - 1; k >= 0; k--) begin
      if (hit[k]) first = IDX_W'(k);
    end
  end

  assign nxt_hit = (first != IDX_W'(NUM_CS - 1)) && hit[first + IDX_W'(1)];

  always_comb begin
    pick = first;
    if (two_bit && (&hit))        pick = {b1, b0};
    else if (one_bit && nxt_hit)  pick = first + IDX_W'(b0);
  end

  assign cs_onehot = (|hit) ? (NUM_CS'(1) << pick) : '0;
endmodule

// File: rtl/csel_decoder.sv
module csel_decoder
  import csdec_pkg::*;
#(
  parameter int ADDR_W   = 40,
  parameter int FIELD_LO = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic                cfg_we,
  input  logic [REG_W-1:0]    cfg_addr,
  input  logic [ADDR_W-1:0]   cfg_wdata,
  output logic                rsp_valid,
  output logic [NUM_CS-1:0]   rsp_cs,
  output logic                rsp_miss,
  output logic                rsp_berr
);
  localparam int FW = ADDR_W - FIELD_LO;

  logic [NUM_CS-1:0][FW-1:0] lo_bound, hi_bound;
  logic [ADDR_W-1:0]         ilv_mask;
  miss_mode_e                miss_mode;
  logic [NUM_CS-1:0]         hit, cs_next;
  logic                      miss_next;

  csdec_regs #(.ADDR_W(ADDR_W), .FW(FW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .waddr(cfg_addr), .wdata(cfg_wdata),
    .lo_bound(lo_bound), .hi_bound(hi_bound), .ilv_mask(ilv_mask), .miss_mode(miss_mode)
  );

  csdec_range_cmp #(.FW(FW)) u_cmp (
    .field(req_addr[ADDR_W-1:FIELD_LO]), .lo_bound(lo_bound), .hi_bound(hi_bound), .hit(hit)
  );

  csdec_select #(.ADDR_W(ADDR_W)) u_sel (
    .hit(hit), .addr(req_addr), .ilv_mask(ilv_mask), .cs_onehot(cs_next)
  );

  assign miss_next = (cs_next == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_cs    <= '0;
      rsp_miss  <= 1'b0;
      rsp_berr  <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_cs    <= req_valid ? cs_next : '0;
      rsp_miss  <= req_valid && miss_next;
      rsp_berr  <= req_valid && miss_next && !req_write && (miss_mode == MISS_BUSERR);
    end
  end
endmodule

// File: rtl/csdec_chk.sv
module csdec_chk
  import csdec_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic              rsp_valid,
  input logic [NUM_CS-1:0] rsp_cs,
  input logic              rsp_miss,
  input logic              rsp_berr
);
  p_cs_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rsp_cs));

  p_miss_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_miss == (rsp_cs == '0)));

  p_berr_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_write |=> !rsp_berr);

  p_berr_miss_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_berr |-> rsp_miss);

  p_resp_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && rsp_cs == '0 && !rsp_miss && !rsp_berr));
endmodule

bind csel_decoder csdec_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .rsp_valid(rsp_valid), .rsp_cs(rsp_cs), .rsp_miss(rsp_miss), .rsp_berr(rsp_berr)
);

// File: tb/csel_decoder_tb_top.sv
module csel_decoder_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [39:0] req_addr = '0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [39:0] cfg_wdata = '0;
  logic        rsp_valid, rsp_miss, rsp_berr;
  logic [3:0]  rsp_cs;

  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  csel_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .rsp_valid(rsp_valid), .rsp_cs(rsp_cs), .rsp_miss(rsp_miss), .rsp_berr(rsp_berr)
  );

  function automatic logic [39:0] mk(input logic [15:0] top, input logic [23:0] low);
    return {top, low};
  endfunction

  task automatic cmp(input string tag, input logic v, input logic [3:0] cs,
                     input logic m, input logic b);
    n_chk++;
    if (rsp_valid !== v || rsp_cs !== cs || rsp_miss !== m || rsp_berr !== b) begin
      n_bad++;
      $display("FAIL %s: got v=%b cs=%b miss=%b berr=%b exp v=%b cs=%b miss=%b berr=%b",
               tag, rsp_valid, rsp_cs, rsp_miss, rsp_berr, v, cs, m, b);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [39:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // one request, response sampled just after the next edge
  task automatic req(input string tag, input logic w, input logic [39:0] a,
                     input logic [3:0] cs, input logic m, input logic b);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a;
    @(posedge clk); #1;
    req_valid = 1'b0;
    cmp(tag, 1'b1, cs, m, b);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 cmp("R11 outputs after reset", 1'b0, 4'b0, 1'b0, 1'b0);
    @(negedge clk) rst_n = 1'b1;
    req("R11 R3 all regions unused, read berr", 1'b0, mk(16'h0, 24'h0), 4'b0, 1'b1, 1'b1);
  endtask

  task automatic t_bounds;
    wr(4'd0, 40'h10); wr(4'd4, 40'h20);
    req("R1 start inclusive",  1'b0, mk(16'h0010, 24'h0), 4'b0001, 1'b0, 1'b0);
    req("R2 end-1 hits",       1'b0, mk(16'h001F, 24'hFFFFFF), 4'b0001, 1'b0, 1'b0);
    req("R2 end exclusive",    1'b0, mk(16'h0020, 24'h0), 4'b0000, 1'b1, 1'b1);
    req("R1 below start miss", 1'b0, mk(16'h000F, 24'hFFFFFF), 4'b0000, 1'b1, 1'b1);
  endtask

  task automatic t_unused;
    wr(4'd1, 40'h0); wr(4'd5, 40'h0);
    req("R3 zero-range region ignored", 1'b1, mk(16'h0, 24'h0), 4'b0, 1'b1, 1'b0);
  endtask

  task automatic t_overlap;
    wr(4'd1, 40'h18); wr(4'd5, 40'h30);
    req("R4 overlap lowest wins", 1'b0, mk(16'h0018, 24'h0), 4'b0001, 1'b0, 1'b0);
    req("R4 only cs1 matches",    1'b0, mk(16'h0020, 24'h0), 4'b0010, 1'b0, 1'b0);
  endtask

  task automatic t_two_way;
    wr(4'd2, 40'h40); wr(4'd6, 40'h60); wr(4'd3, 40'h40); wr(4'd7, 40'h60);
    req("R4 pair, zero mask lowest", 1'b0, mk(16'h0040, 24'h001000), 4'b0100, 1'b0, 1'b0);
    wr(4'd8, 40'h1000);
    req("R10 R5 bit12=0 -> cs2", 1'b0, mk(16'h0040, 24'h000000), 4'b0100, 1'b0, 1'b0);
    req("R5 bit12=1 -> cs3",     1'b1, mk(16'h0041, 24'h001000), 4'b1000, 1'b0, 1'b0);
    wr(4'd8, 40'h5000);
    req("R4 non-adjacent mask lowest", 1'b0, mk(16'h0040, 24'h001000), 4'b0100, 1'b0, 1'b0);
  endtask

  task automatic t_four_way;
    for (int i = 0; i < 4; i++) begin
      wr(4'(i), 40'h80); wr(4'(i + 4), 40'hC0);
    end
    wr(4'd8, 40'h3000);
    for (int i = 0; i < 4; i++)
      req($sformatf("R6 index %0d", i), 1'b0, mk(16'h0090, 24'(i) << 12),
          4'b0001 << i, 1'b0, 1'b0);
    req("R2 R6 end exclusive", 1'b0, mk(16'h00C0, 24'h003000), 4'b0, 1'b1, 1'b1);
  endtask

  task automatic t_miss;
    req("R7 write miss no berr", 1'b1, mk(16'hFFFF, 24'h0), 4'b0, 1'b1, 1'b0);
    req("R8 read miss berr",     1'b0, mk(16'hFFFF, 24'h0), 4'b0, 1'b1, 1'b1);
    wr(4'd9, 40'h1);
    req("R8 R10 read miss valid data", 1'b0, mk(16'hFFFF, 24'h0), 4'b0, 1'b1, 1'b0);
  endtask

  task automatic t_backtoback;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = mk(16'h0080, 24'h0);
    @(posedge clk); #1;
    req_addr = mk(16'h0001, 24'h0);
    cmp("R9 first of pair", 1'b1, 4'b0001, 1'b0, 1'b0);
    @(posedge clk); #1;
    req_valid = 1'b0;
    cmp("R9 second of pair", 1'b1, 4'b0000, 1'b1, 1'b0);
    @(posedge clk); #1;
    cmp("R9 quiet after", 1'b0, 4'b0, 1'b0, 1'b0);
  endtask

  initial begin
    t_reset;
    t_bounds;
    t_unused;
    t_overlap;
    t_two_way;
    t_four_way;
    t_miss;
    t_backtoback;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got running exp finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule